// File: doc/BRIEF.md
# PAM-4 Decision-Feedback Slicer with Sign-Sign Tap Adaptation

This block is the decision stage of a four-level receiver. Each cycle with `in_valid` high it takes one signed digitized sample and subtracts a feedback correction. The correction is formed from the symbols the block itself decided on earlier, each weighted by its own feedback tap. The corrected value is compared with three thresholds to choose one of four amplitude levels. The level and its Gray-coded bit pair leave the block one cycle later, together with the sign of the residual error.

The residual error is the corrected value minus the ideal amplitude of the chosen level. Its sign, together with the sign of each stored past decision, moves every tap one fixed step per symbol. The steps push the taps toward the values that cancel the post-cursor interference of the channel. Software can pick one of three step sizes, stop adaptation, or zero the taps, and all taps are visible on a flat read-back bus.

Amplitudes are expressed in units of the parameter `LVL_UNIT` (U), in sample LSBs. The four ideal levels are -3U, -U, +U and +3U. The level codes 0, 1, 2 and 3 name them in that order.

Top module: `pam4_dfe_slicer`

## Requirements
- R1: The corrected value y is sliced to level code 0 when y < -2U, to 1 when -2U <= y < 0, to 2 when 0 <= y < 2U, and to 3 when y >= 2U. A value exactly on a threshold takes the higher level.
- R2: `out_gray` encodes the level: code 0 gives 00, code 1 gives 01, code 2 gives 11 and code 3 gives 10.
- R3: y equals the sample minus the sum over k of tap k times the amplitude (-3, -1, +1, +3 for codes 0..3) of the decision made k+1 samples earlier. History slots not yet filled since reset contribute nothing and their taps are not adapted.
- R4: After reset `out_valid` is low and all taps are zero. Results are registered: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high.
- R5: `out_err_neg` is 1 when y is below the ideal amplitude of the decided level, and 0 otherwise.
- R6: For each valid sample with `freeze` and `clear` low, each tap with a filled slot moves up by the step when (error >= 0) equals (its stored decision is code 2 or 3). Otherwise it moves down by the step.
- R7: `step_sel` picks the step: 0 gives 1 LSB, 1 gives 2 LSB, and 2 or 3 give 4 LSB.
- R8: Taps saturate at -2^(TAP_W-1) and 2^(TAP_W-1)-1 and never wrap.
- R9: Taps hold their values while `freeze` is high or while `in_valid` is low.
- R10: `clear` zeroes every tap at the next edge. It takes priority over `freeze` and over adaptation, and it leaves the decision history untouched.
- R11: The history stores the sliced decisions, not the samples, so a decision feeds the corrections of the following symbols whether or not it was right.
- R12: `tap_o` carries tap k in bits [k*TAP_W +: TAP_W]. Tap 0 weights the most recent decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample present this cycle |
| in_sample | input | SAMPLE_W | Signed digitized receive sample |
| step_sel | input | 2 | Adaptation step select |
| freeze | input | 1 | Hold all taps |
| clear | input | 1 | Zero all taps |
| out_valid | output | 1 | Result valid, one cycle after the sample |
| out_level | output | 2 | Decided level code |
| out_gray | output | 2 | Gray-coded bit pair of the decision |
| out_err_neg | output | 1 | Residual error is negative |
| tap_o | output | NUM_TAPS*TAP_W | All feedback taps, read back |

## Verification
The bench builds the block with SAMPLE_W=8, NUM_TAPS=3, LVL_UNIT=16 and TAP_W narrowed to 4. With 4-bit taps, a handful of 4-LSB steps drives every tap into its clamp, so saturation is reached well inside the run. The ±128 sample range also reaches well beyond the outer levels, so all three thresholds, including exact threshold values, can be hit. Large saturated taps make a single decision swing the next correction by dozens of LSBs, which lets the bench show feedback of a decided level into the following slice. A pseudo-random channel with two post-cursors, toggling freeze and step size, then exercises adaptation against the scoreboard.

// File: rtl/pam4_dfe_pkg.sv
package pam4_dfe_pkg;

   typedef logic [1:0] lvl_t;

   // Gray pair for a level code
   function automatic logic [1:0] lvl_to_gray(input lvl_t l);
      logic [1:0] g;
      case (l)
         2'd0:    g = 2'b00;
         2'd1:    g = 2'b01;
         2'd2:    g = 2'b11;
         default: g = 2'b10;
      endcase
      return g;
   endfunction

   // Adaptation step in LSB for a step select code
   function automatic logic [2:0] step_lsb(input logic [1:0] sel);
      logic [2:0] s;
      case (sel)
         2'd0:    s = 3'd1;
         2'd1:    s = 3'd2;
         default: s = 3'd4;
      endcase
      return s;
   endfunction

   // Positive amplitude (codes 2 and 3)
   function automatic logic lvl_is_pos(input lvl_t l);
      return (l >= 2'd2);
   endfunction

endpackage

// File: rtl/dfe_hist.sv
module dfe_hist
   import pam4_dfe_pkg::*;
#(
   parameter int DEPTH = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  shift_en,
   input  lvl_t                  new_lvl,
   output lvl_t [DEPTH-1:0]      lvl_q,
   output logic [DEPTH-1:0]      vld_q
);

   genvar k;
   generate
      for (k = 0; k < DEPTH; k++) begin : g_slot
         if (k == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  lvl_q[k] <= '0;
                  vld_q[k] <= 1'b0;
               end else if (shift_en) begin
                  lvl_q[k] <= new_lvl;
                  vld_q[k] <= 1'b1;
               end
            end
         end else begin : g_tail
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  lvl_q[k] <= '0;
                  vld_q[k] <= 1'b0;
               end else if (shift_en) begin
                  lvl_q[k] <= lvl_q[k-1];
                  vld_q[k] <= vld_q[k-1];
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/dfe_tap_bank.sv
module dfe_tap_bank
   import pam4_dfe_pkg::*;
#(
   parameter int NUM_TAPS = 3,
   parameter int TAP_W    = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       upd_en,
   input  logic                       clear,
   input  logic                       err_neg,
   input  logic [1:0]                 step_sel,
   input  lvl_t [NUM_TAPS-1:0]        hist_lvl,
   input  logic [NUM_TAPS-1:0]        hist_vld,
   output logic [NUM_TAPS*TAP_W-1:0]  taps_flat
);

   localparam int SUM_W = TAP_W + 1;
   localparam logic signed [SUM_W-1:0] T_MAX = SUM_W'((2 ** (TAP_W - 1)) - 1);
   localparam logic signed [SUM_W-1:0] T_MIN = SUM_W'(-(2 ** (TAP_W - 1)));

   logic [2:0]              stp;
   logic signed [SUM_W-1:0] step_x;

   always_comb begin
      stp    = step_lsb(step_sel);
      step_x = {{(SUM_W - 3){1'b0}}, stp};
   end

   genvar k;
   generate
      for (k = 0; k < NUM_TAPS; k++) begin : g_tap
         logic signed [TAP_W-1:0] t_q;
         logic signed [TAP_W-1:0] t_sat;
         logic signed [SUM_W-1:0] t_x;
         logic signed [SUM_W-1:0] t_sum;
         logic                    go_up;

         always_comb begin
            t_x   = {t_q[TAP_W-1], t_q};
            go_up = (!err_neg) == lvl_is_pos(hist_lvl[k]);
            t_sum = go_up ? (t_x + step_x) : (t_x - step_x);
            if (t_sum > T_MAX)
               t_sat = T_MAX[TAP_W-1:0];
            else if (t_sum < T_MIN)
               t_sat = T_MIN[TAP_W-1:0];
            else
               t_sat = t_sum[TAP_W-1:0];
         end

         always_ff @(posedge clk) begin
            if (!rst_n)
               t_q <= '0;
            else if (clear)
               t_q <= '0;
            else if (upd_en && hist_vld[k])
               t_q <= t_sat;
         end

         assign taps_flat[k*TAP_W +: TAP_W] = t_q;
      end
   endgenerate

endmodule

// File: rtl/dfe_feedback_sum.sv
module dfe_feedback_sum
   import pam4_dfe_pkg::*;
#(
   parameter int NUM_TAPS = 3,
   parameter int TAP_W    = 8,
   parameter int SAMPLE_W = 8,
   parameter int EQ_W     = 13
) (
   input  logic [SAMPLE_W-1:0]        sample,
   input  logic [NUM_TAPS*TAP_W-1:0]  taps_flat,
   input  lvl_t [NUM_TAPS-1:0]        hist_lvl,
   input  logic [NUM_TAPS-1:0]        hist_vld,
   output logic signed [EQ_W-1:0]     eq
);

   localparam logic signed [EQ_W-1:0] A_N3 = EQ_W'(-3);
   localparam logic signed [EQ_W-1:0] A_N1 = EQ_W'(-1);
   localparam logic signed [EQ_W-1:0] A_P1 = EQ_W'(1);
   localparam logic signed [EQ_W-1:0] A_P3 = EQ_W'(3);

   logic signed [EQ_W-1:0] prod [NUM_TAPS];

   genvar k;
   generate
      for (k = 0; k < NUM_TAPS; k++) begin : g_prod
         logic signed [TAP_W-1:0] t_s;
         logic signed [EQ_W-1:0]  t_x;
         logic signed [EQ_W-1:0]  amp;

         always_comb begin
            t_s = taps_flat[k*TAP_W +: TAP_W];
            t_x = {{(EQ_W - TAP_W){t_s[TAP_W-1]}}, t_s};
            case (hist_lvl[k])
               2'd0:    amp = A_N3;
               2'd1:    amp = A_N1;
               2'd2:    amp = A_P1;
               default: amp = A_P3;
            endcase
            prod[k] = hist_vld[k] ? (t_x * amp) : '0;
         end
      end
   endgenerate

   logic signed [EQ_W-1:0] acc;
   logic signed [EQ_W-1:0] smp_x;

   always_comb begin
      acc = '0;
      for (int i = 0; i < NUM_TAPS; i++)
         acc = acc + prod[i];
      smp_x = {{(EQ_W - SAMPLE_W){sample[SAMPLE_W-1]}}, sample};
      eq    = smp_x - acc;
   end

endmodule

// File: rtl/pam4_level_slicer.sv
module pam4_level_slicer
   import pam4_dfe_pkg::*;
#(
   parameter int EQ_W     = 13,
   parameter int LVL_UNIT = 16
) (
   input  logic signed [EQ_W-1:0] eq,
   output lvl_t                   lvl,
   output logic [1:0]             gray,
   output logic                   err_neg
);

   localparam logic signed [EQ_W-1:0] TH_HI = EQ_W'(2 * LVL_UNIT);
   localparam logic signed [EQ_W-1:0] TH_LO = EQ_W'(-2 * LVL_UNIT);
   localparam logic signed [EQ_W-1:0] TH_MID = '0;
   localparam logic signed [EQ_W-1:0] ID_0 = EQ_W'(-3 * LVL_UNIT);
   localparam logic signed [EQ_W-1:0] ID_1 = EQ_W'(-LVL_UNIT);
   localparam logic signed [EQ_W-1:0] ID_2 = EQ_W'(LVL_UNIT);
   localparam logic signed [EQ_W-1:0] ID_3 = EQ_W'(3 * LVL_UNIT);

   logic signed [EQ_W-1:0] ideal;

   always_comb begin
      if (eq < TH_LO)
         lvl = 2'd0;
      else if (eq < TH_MID)
         lvl = 2'd1;
      else if (eq < TH_HI)
         lvl = 2'd2;
      else
         lvl = 2'd3;

      case (lvl)
         2'd0:    ideal = ID_0;
         2'd1:    ideal = ID_1;
         2'd2:    ideal = ID_2;
         default: ideal = ID_3;
      endcase

      err_neg = (eq < ideal);
      gray    = lvl_to_gray(lvl);
   end

endmodule

// File: rtl/pam4_dfe_slicer.sv
module pam4_dfe_slicer
   import pam4_dfe_pkg::*;
#(
   parameter int SAMPLE_W = 8,
   parameter int NUM_TAPS = 3,
   parameter int TAP_W    = 8,
   parameter int LVL_UNIT = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic [SAMPLE_W-1:0]        in_sample,
   input  logic [1:0]                 step_sel,
   input  logic                       freeze,
   input  logic                       clear,
   output logic                       out_valid,
   output logic [1:0]                 out_level,
   output logic [1:0]                 out_gray,
   output logic                       out_err_neg,
   output logic [NUM_TAPS*TAP_W-1:0]  tap_o
);

   localparam int PROD_W = TAP_W + 2;
   localparam int ACC_W  = PROD_W + $clog2(NUM_TAPS);
   localparam int EQ_W   = ((SAMPLE_W > ACC_W) ? SAMPLE_W : ACC_W) + 1;

   initial begin
      assert (SAMPLE_W >= 6)
         else $fatal(1, "SAMPLE_W must be at least 6");
      assert (NUM_TAPS >= 1)
         else $fatal(1, "NUM_TAPS must be at least 1");
      assert (TAP_W >= 4)
         else $fatal(1, "TAP_W must be at least 4");
      assert (LVL_UNIT >= 1 && 3 * LVL_UNIT < 2 ** (SAMPLE_W - 1))
         else $fatal(1, "LVL_UNIT does not fit the sample range");
   end

   lvl_t [NUM_TAPS-1:0]    hist_lvl;
   logic [NUM_TAPS-1:0]    hist_vld;
   logic signed [EQ_W-1:0] eq;
   lvl_t                   dec_lvl;
   logic [1:0]             dec_gray;
   logic                   dec_err_neg;

   dfe_feedback_sum #(
      .NUM_TAPS (NUM_TAPS),
      .TAP_W    (TAP_W),
      .SAMPLE_W (SAMPLE_W),
      .EQ_W     (EQ_W)
   ) i_sum (
      .sample    (in_sample),
      .taps_flat (tap_o),
      .hist_lvl  (hist_lvl),
      .hist_vld  (hist_vld),
      .eq        (eq)
   );

   pam4_level_slicer #(
      .EQ_W     (EQ_W),
      .LVL_UNIT (LVL_UNIT)
   ) i_slice (
      .eq      (eq),
      .lvl     (dec_lvl),
      .gray    (dec_gray),
      .err_neg (dec_err_neg)
   );

   dfe_hist #(
      .DEPTH (NUM_TAPS)
   ) i_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (in_valid),
      .new_lvl  (dec_lvl),
      .lvl_q    (hist_lvl),
      .vld_q    (hist_vld)
   );

   dfe_tap_bank #(
      .NUM_TAPS (NUM_TAPS),
      .TAP_W    (TAP_W)
   ) i_taps (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd_en    (in_valid && !freeze),
      .clear     (clear),
      .err_neg   (dec_err_neg),
      .step_sel  (step_sel),
      .hist_lvl  (hist_lvl),
      .hist_vld  (hist_vld),
      .taps_flat (tap_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_level   <= '0;
         out_gray    <= '0;
         out_err_neg <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_level   <= dec_lvl;
            out_gray    <= dec_gray;
            out_err_neg <= dec_err_neg;
         end
      end
   end

endmodule

// File: rtl/pam4_dfe_chk.sv
module pam4_dfe_chk #(
   parameter int NUM_TAPS = 3,
   parameter int TAP_W    = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       in_valid,
   input logic                       freeze,
   input logic                       clear,
   input logic                       out_valid,
   input logic [1:0]                 out_level,
   input logic [1:0]                 out_gray,
   input logic [NUM_TAPS*TAP_W-1:0]  tap_o
);

   localparam logic signed [TAP_W:0] STEP_LIM = (TAP_W + 1)'(4);

   logic                       armed;
   logic                       clr_q;
   logic [NUM_TAPS*TAP_W-1:0]  tap_prev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed    <= 1'b0;
         clr_q    <= 1'b0;
         tap_prev <= '0;
      end else begin
         armed    <= 1'b1;
         clr_q    <= clear;
         tap_prev <= tap_o;
      end
   end

   // R4
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R4
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R2
   gray_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_gray[1] == out_level[1]) &&
                    (out_gray[0] == (out_level[1] ^ out_level[0])));

   // R10
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (tap_o == '0));

   // R9
   freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && !clear) |=> $stable(tap_o));

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && !clear) |=> $stable(tap_o));

   genvar k;
   generate
      for (k = 0; k < NUM_TAPS; k++) begin : g_step
         logic signed [TAP_W-1:0] cur_s;
         logic signed [TAP_W-1:0] old_s;
         logic signed [TAP_W:0]   dlt;
         logic                    dlt_ok;

         always_comb begin
            cur_s  = tap_o[k*TAP_W +: TAP_W];
            old_s  = tap_prev[k*TAP_W +: TAP_W];
            dlt    = {cur_s[TAP_W-1], cur_s} - {old_s[TAP_W-1], old_s};
            dlt_ok = (dlt <= STEP_LIM) && (dlt >= -STEP_LIM);
         end

         // R8
         no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && !clr_q) |-> dlt_ok);
      end
   endgenerate

endmodule

bind pam4_dfe_slicer pam4_dfe_chk #(
   .NUM_TAPS (NUM_TAPS),
   .TAP_W    (TAP_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .freeze    (freeze),
   .clear     (clear),
   .out_valid (out_valid),
   .out_level (out_level),
   .out_gray  (out_gray),
   .tap_o     (tap_o)
);

// File: tb/test_pam4_dfe_slicer.sv
module test_pam4_dfe_slicer;

   localparam int SAMPLE_W = 8;
   localparam int NUM_TAPS = 3;
   localparam int TAP_W    = 4;
   localparam int LVL_UNIT = 16;
   localparam int TMAX     = (2 ** (TAP_W - 1)) - 1;
   localparam int TMIN     = -(2 ** (TAP_W - 1));

   logic                       clk = 1'b0;
   logic                       rst_n = 1'b0;
   logic                       in_valid = 1'b0;
   logic [SAMPLE_W-1:0]        in_sample = '0;
   logic [1:0]                 step_sel = 2'd0;
   logic                       freeze = 1'b0;
   logic                       clear = 1'b0;
   logic                       out_valid;
   logic [1:0]                 out_level;
   logic [1:0]                 out_gray;
   logic                       out_err_neg;
   logic [NUM_TAPS*TAP_W-1:0]  tap_o;

   always #4 clk = ~clk;

   pam4_dfe_slicer #(
      .SAMPLE_W (SAMPLE_W),
      .NUM_TAPS (NUM_TAPS),
      .TAP_W    (TAP_W),
      .LVL_UNIT (LVL_UNIT)
   ) i_pam4_dfe_slicer (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_sample   (in_sample),
      .step_sel    (step_sel),
      .freeze      (freeze),
      .clear       (clear),
      .out_valid   (out_valid),
      .out_level   (out_level),
      .out_gray    (out_gray),
      .out_err_neg (out_err_neg),
      .tap_o       (tap_o)
   );

   typedef struct {
      int lvl;
      int gray;
      int eneg;
      int t0;
      int t1;
      int t2;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0;
   int   n_err = 0;

   // reference state
   int m_tap[NUM_TAPS];
   int m_hl[NUM_TAPS];
   int m_hv[NUM_TAPS];

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   function automatic int rd_tap(input int k);
      logic signed [TAP_W-1:0] v;
      v = tap_o[k*TAP_W +: TAP_W];
      return int'(v);
   endfunction

   function automatic int gray_of(input int l);
      case (l)
         0: return 0;
         1: return 1;
         2: return 3;
         default: return 2;
      endcase
   endfunction

   function automatic int amp_of(input int l);
      return 2 * l - 3;
   endfunction

   task automatic model_reset();
      for (int k = 0; k < NUM_TAPS; k++) begin
         m_tap[k] = 0;
         m_hl[k]  = 0;
         m_hv[k]  = 0;
      end
   endtask

   // one cycle of stimulus; returns just after the capturing edge
   task automatic drive(input bit vld, input int x, input bit fr, input bit clr, input int stp);
      int   y;
      int   lvl;
      int   e;
      int   st;
      exp_t it;
      @(negedge clk);
      in_valid  = vld;
      in_sample = SAMPLE_W'(x);
      freeze    = fr;
      clear     = clr;
      step_sel  = 2'(stp);
      if (vld) begin
         y = x;
         for (int k = 0; k < NUM_TAPS; k++)
            if (m_hv[k] != 0) y = y - m_tap[k] * amp_of(m_hl[k]);
         if (y < -2 * LVL_UNIT)      lvl = 0;
         else if (y < 0)             lvl = 1;
         else if (y < 2 * LVL_UNIT)  lvl = 2;
         else                        lvl = 3;
         e  = y - amp_of(lvl) * LVL_UNIT;
         st = (stp == 0) ? 1 : (stp == 1) ? 2 : 4;
         if (!clr && !fr) begin
            for (int k = 0; k < NUM_TAPS; k++) begin
               if (m_hv[k] != 0) begin
                  if ((e >= 0) == (m_hl[k] >= 2)) m_tap[k] = m_tap[k] + st;
                  else                            m_tap[k] = m_tap[k] - st;
                  if (m_tap[k] > TMAX) m_tap[k] = TMAX;
                  if (m_tap[k] < TMIN) m_tap[k] = TMIN;
               end
            end
         end
         for (int k = NUM_TAPS - 1; k > 0; k--) begin
            m_hl[k] = m_hl[k-1];
            m_hv[k] = m_hv[k-1];
         end
         m_hl[0] = lvl;
         m_hv[0] = 1;
      end
      if (clr)
         for (int k = 0; k < NUM_TAPS; k++) m_tap[k] = 0;
      if (vld) begin
         it.lvl  = lvl;
         it.gray = gray_of(lvl);
         it.eneg = (e < 0) ? 1 : 0;
         it.t0   = m_tap[0];
         it.t1   = m_tap[1];
         it.t2   = m_tap[2];
         q.push_back(it);
      end
      @(posedge clk);
      #2;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(1'b0, 0, freeze, 1'b0, int'(step_sel));
   endtask

   task automatic chk_taps(input string req, input int a, input int b, input int c);
      chk(rd_tap(0) == a, req, rd_tap(0), a);
      chk(rd_tap(1) == b, req, rd_tap(1), b);
      chk(rd_tap(2) == c, req, rd_tap(2), c);
   endtask

   // monitor: scoreboard pop
   always @(posedge clk) begin
      #1;
      if (rst_n && out_valid) begin
         if (q.size() == 0) begin
            chk(1'b0, "R4 unexpected out_valid", 1, 0);
         end else begin
            exp_t it;
            it = q.pop_front();
            chk(int'(out_level) == it.lvl, "R1 level", int'(out_level), it.lvl);
            chk(int'(out_gray) == it.gray, "R2 gray", int'(out_gray), it.gray);
            chk(int'(out_err_neg) == it.eneg, "R5 error sign", int'(out_err_neg), it.eneg);
            chk(rd_tap(0) == it.t0, "R6 tap0", rd_tap(0), it.t0);
            chk(rd_tap(1) == it.t1, "R6 tap1", rd_tap(1), it.t1);
            chk(rd_tap(2) == it.t2, "R6 tap2", rd_tap(2), it.t2);
         end
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      n_chk++;
      $display("FAIL R4 watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   int unsigned seed;
   int          xs[12];
   int          prev1;
   int          prev2;

   initial begin
      model_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #2;
      // R4 reset state
      chk(out_valid == 1'b0, "R4 reset valid", int'(out_valid), 0);
      chk_taps("R4 reset taps", 0, 0, 0);

      // R1/R2/R5: thresholds and levels with taps at zero and frozen
      xs = '{-128, -33, -32, -1, 0, 31, 32, 127, -48, -16, 16, 48};
      foreach (xs[i]) drive(1'b1, xs[i], 1'b1, 1'b0, 2);
      // R9 frozen taps stay zero
      chk_taps("R9 freeze hold", 0, 0, 0);
      idle(2);
      chk(out_valid == 1'b0, "R4 idle valid", int'(out_valid), 0);

      // R8: saturation at upper limit with 4-LSB steps
      for (int i = 0; i < 10; i++) drive(1'b1, 127, 1'b0, 1'b0, 2);
      chk_taps("R8 saturate", TMAX, TMAX, TMAX);

      // R11: decided levels feed later corrections
      drive(1'b1, 0, 1'b1, 1'b0, 2);
      chk(int'(out_level) == 0, "R11 first decision", int'(out_level), 0);
      drive(1'b1, 0, 1'b1, 1'b0, 2);
      chk(int'(out_level) == 1, "R11 fed-back decision", int'(out_level), 1);
      for (int i = 0; i < 3; i++) drive(1'b1, 127, 1'b1, 1'b0, 2);

      // R10: clear wins over freeze, idle cycle
      drive(1'b0, 0, 1'b1, 1'b1, 2);
      chk_taps("R10 clear", 0, 0, 0);

      // R7: step sizes 1, 2, 4 (code 3)
      drive(1'b1, 127, 1'b0, 1'b0, 0);
      chk_taps("R7 step 1", 1, 1, 1);
      drive(1'b1, 127, 1'b0, 1'b0, 1);
      chk_taps("R7 step 2", 3, 3, 3);
      drive(1'b1, 127, 1'b0, 1'b0, 3);
      chk_taps("R7 step 4", 7, 7, 7);

      // R9: no valid input holds taps
      idle(3);
      chk_taps("R9 idle hold", 7, 7, 7);

      // R10: clear during a valid sample overrides adaptation
      drive(1'b1, 127, 1'b0, 1'b1, 2);
      chk_taps("R10 clear with sample", 0, 0, 0);

      // R3/R12: empty history after reset, tap order
      @(negedge clk);
      rst_n = 1'b0;
      in_valid = 1'b0;
      @(negedge clk);
      q.delete();
      model_reset();
      rst_n = 1'b1;
      drive(1'b1, 127, 1'b0, 1'b0, 0);
      chk_taps("R3 empty history", 0, 0, 0);
      drive(1'b1, 127, 1'b0, 1'b0, 0);
      chk_taps("R12 tap order one", 1, 0, 0);
      drive(1'b1, 127, 1'b0, 1'b0, 0);
      chk_taps("R12 tap order two", 2, 1, 0);

      // R6: channel with two post-cursors, adaptive run
      seed  = 32'h1234_5678;
      prev1 = 2;
      prev2 = 1;
      for (int i = 0; i < 600; i++) begin
         int sym;
         int x;
         int nz;
         seed = seed * 1103515245 + 12345;
         sym  = int'((seed >> 16) & 3);
         nz   = int'((seed >> 20) % 7) - 3;
         x    = amp_of(sym) * LVL_UNIT + 6 * amp_of(prev1) - 3 * amp_of(prev2) + nz;
         if (x > 127)  x = 127;
         if (x < -128) x = -128;
         drive(1'b1, x, (i % 50) >= 45, (i == 300), (i / 150) % 4);
         prev2 = prev1;
         prev1 = sym;
      end
      idle(3);
      chk(q.size() == 0, "R4 all results seen", q.size(), 0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule